// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Hidden Refresh

This block decides when and how a dynamic RAM array gets refreshed on a 32-bit CPU board. A free-running prescaler turns the CPU clock into a periodic refresh tick, and every tick adds one refresh to an "owed" count. While a refresh is owed, the scheduler watches the processor bus. Any bus cycle that does not touch the RAM array is an opportunity. The scheduler takes it as a hidden refresh at no cost to the processor. Cycles to the floating-point coprocessor are such opportunities even when the board's RAM select is active.

If no opportunity shows up within a set number of clocks, the scheduler stops waiting. It raises a refresh request to the bus arbiter and holds it until the arbiter acknowledges. It then runs its own refresh cycle, in which RAS is asserted and CAS is kept off, followed by a precharge gap. Each finished refresh, hidden or arbitrated, advances the row counter that the address multiplexer uses during refresh.

Top module: `rfsh_sched`

## Requirements
- R1: During and right after reset, rfsh_req, ras_act, cas_block and hidden_go are 0 and rfsh_row is 0.
- R2: The prescaler adds one owed refresh every PRESCALE clocks; the first is owed from clock edge PRESCALE after reset release.
- R3: While a refresh is owed and rfsh_req is low, a clock with cyc_strobe high on an opportunity drives hidden_go high in that same clock; that edge completes one refresh.
- R4: An opportunity is a cycle with ram_sel low, or a coprocessor cycle whatever ram_sel says: bus_fc = 3'b111, bus_addr[19:16] = 4'b0010 and bus_addr[15:13] = 3'b001. Any other cycle with ram_sel high is not an opportunity.
- R5: If no hidden refresh is taken, rfsh_req rises WAIT_CLKS clocks after the oldest owed refresh became due. From reset, this is at edge PRESCALE + WAIT_CLKS.
- R6: rfsh_req stays high until rfsh_ack is sampled high, and ras_act stays low until then.
- R7: ras_act is high for exactly RAS_CLKS clocks, starting in the clock after rfsh_ack is sampled; cas_block is high with it.
- R8: After the RAS phase, a precharge gap of PRECHG_CLKS clocks follows, with rfsh_req and cas_block still high; rfsh_req goes low in the next clock.
- R9: rfsh_row increases by one after each completed refresh of either kind and wraps modulo 2^ROW_BITS.
- R10: Ticks that arrive while refreshes are already owed accumulate, saturating at 2^OWE_BITS-1 owed refreshes, and each owed refresh is later completed.
- R11: hidden_go is never high while rfsh_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_strobe | input | 1 | A bus cycle is in progress with a valid address |
| ram_sel | input | 1 | Address decode selects the RAM array |
| bus_fc | input | 3 | Processor function code of the current cycle |
| bus_addr | input | 7 | Address bits 19 down to 13 of the current cycle |
| rfsh_ack | input | 1 | Arbiter grants the bus for a refresh |
| rfsh_req | output | 1 | Refresh bus request to the arbiter |
| ras_act | output | 1 | Row strobe for the RAS-only refresh cycle |
| cas_block | output | 1 | Hold CAS off during the arbitrated refresh cycle |
| hidden_go | output | 1 | Take a hidden refresh in this bus cycle |
| rfsh_row | output | ROW_BITS | Row to refresh next |

## Verification
The bench builds the block with PRESCALE 16, WAIT_CLKS 250, RAS_CLKS 3, PRECHG_CLKS 2, ROW_BITS 3 and OWE_BITS 2. The short prescaler fills the owed count to its 3-entry limit within a few dozen clocks, and 3 row bits give a row wrap within about a dozen refreshes. The long wait window leaves room for a full sweep of all 2048 combinations of function code, address bits and RAM select while a refresh is owed. With 3 and 2 clocks for RAS and precharge, each clock of the arbitrated cycle can be checked one by one.

// File: rtl/rfsh_pkg.sv
// Shared types and the coprocessor cycle decode for the refresh scheduler.
// Assumes address bits 19..13 are presented as a 7-bit field [19:13].
package rfsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RAS  = 2'd2,
        ST_PRE  = 2'd3
    } rfsh_state_e;

    localparam logic [2:0] COP_FC     = 3'b111;
    localparam logic [3:0] COP_A19_16 = 4'b0010;
    localparam logic [2:0] COP_A15_13 = 3'b001;

    // True when the cycle addresses the floating-point coprocessor
    function automatic logic is_cop_cycle(input logic [2:0] fc, input logic [3:0] a_hi,
                                          input logic [2:0] a_lo);
        return (fc == COP_FC) && (a_hi == COP_A19_16) && (a_lo == COP_A15_13);
    endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
// Divides the CPU clock by DIV and produces a one-clock tick in the last
// count of each period. Assumes DIV >= 2.
module rfsh_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running modulo-DIV counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/rfsh_owed_ctr.sv
// Counts refreshes that are due but not yet done. A tick adds one, and a
// completion removes one. Both in the same clock cancel. Saturates at all-ones.
// Assumes done is only raised while pending is high.
module rfsh_owed_ctr #(
    parameter int OWE_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic done,
    output logic pending
);
    localparam logic [OWE_BITS-1:0] OMAX = '1;

    logic [OWE_BITS-1:0] owed;

    // Saturating up/down count of owed refreshes
    always_ff @(posedge clk) begin
        if (!rst_n)                            owed <= '0;
        else if (tick && !done && owed != OMAX) owed <= owed + 1'b1;
        else if (!tick && done)                 owed <= owed - 1'b1;
    end

    assign pending = (owed != '0);
endmodule

// File: rtl/rfsh_cycle_fsm.sv
// Sequencer for one refresh at a time. It takes a hidden refresh when an
// opportunity arrives while a refresh is pending. Otherwise it times out into
// a bus request, then runs RAS, then precharge. Assumes all three clock
// counts are >= 1 and that rfsh_ack is only meaningful while requesting.
module rfsh_cycle_fsm
    import rfsh_pkg::*;
#(
    parameter int WAIT_CLKS   = 32,
    parameter int RAS_CLKS    = 3,
    parameter int PRECHG_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic opp,
    input  logic ack,
    output logic req,
    output logic ras_act,
    output logic cas_block,
    output logic hidden_go,
    output logic done
);
    localparam int M1   = (WAIT_CLKS > RAS_CLKS) ? WAIT_CLKS : RAS_CLKS;
    localparam int MAXC = (M1 > PRECHG_CLKS) ? M1 : PRECHG_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CLKS - 1);
    localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_CLKS - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRECHG_CLKS - 1);

    rfsh_state_e   state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          fin;

    // Next-state and phase-counter decisions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        hidden_go = 1'b0;
        fin       = 1'b0;
        case (state)
            ST_IDLE: begin
                if (pending && opp) begin
                    hidden_go = 1'b1;
                    cnt_nxt   = '0;
                end else if (pending) begin
                    if (cnt == WAIT_LAST) begin
                        state_nxt = ST_REQ;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end else begin
                    cnt_nxt = '0;
                end
            end
            ST_REQ: begin
                if (ack) begin
                    state_nxt = ST_RAS;
                    cnt_nxt   = '0;
                end
            end
            ST_RAS: begin
                if (cnt == RAS_LAST) begin
                    state_nxt = ST_PRE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                if (cnt == PRE_LAST) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                    fin       = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
        endcase
    end

    // State and phase counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign req       = (state != ST_IDLE);
    assign ras_act   = (state == ST_RAS);
    assign cas_block = (state == ST_RAS) || (state == ST_PRE);
    assign done      = hidden_go || fin;
endmodule

// File: rtl/rfsh_sched.sv
// Top of the refresh scheduler. It decodes hidden-refresh opportunities from
// the bus, ties together the prescaler, the owed count and the sequencer, and
// keeps the refresh row counter. Assumes the bus inputs are synchronous to clk.
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int PRESCALE    = 128,
    parameter int WAIT_CLKS   = 32,
    parameter int RAS_CLKS    = 3,
    parameter int PRECHG_CLKS = 2,
    parameter int ROW_BITS    = 9,
    parameter int OWE_BITS    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_strobe,
    input  logic                ram_sel,
    input  logic [2:0]          bus_fc,
    input  logic [19:13]        bus_addr,
    input  logic                rfsh_ack,
    output logic                rfsh_req,
    output logic                ras_act,
    output logic                cas_block,
    output logic                hidden_go,
    output logic [ROW_BITS-1:0] rfsh_row
);
    logic tick, pending, opp, done, cop_hit;

    // Opportunity: any strobed cycle that leaves the RAM array idle
    always_comb begin
        cop_hit = is_cop_cycle(bus_fc, bus_addr[19:16], bus_addr[15:13]);
        opp     = cyc_strobe && (!ram_sel || cop_hit);
    end

    rfsh_prescaler #(.DIV(PRESCALE)) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfsh_owed_ctr #(.OWE_BITS(OWE_BITS)) owe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .done    (done),
        .pending (pending)
    );

    rfsh_cycle_fsm #(
        .WAIT_CLKS   (WAIT_CLKS),
        .RAS_CLKS    (RAS_CLKS),
        .PRECHG_CLKS (PRECHG_CLKS)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .opp       (opp),
        .ack       (rfsh_ack),
        .req       (rfsh_req),
        .ras_act   (ras_act),
        .cas_block (cas_block),
        .hidden_go (hidden_go),
        .done      (done)
    );

    // Row counter advances once per completed refresh, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)    rfsh_row <= '0;
        else if (done) rfsh_row <= rfsh_row + 1'b1;
    end
endmodule

// File: rtl/rfsh_sched_chk.sv
// Property checker for rfsh_sched, attached to every instance by bind.
// Watches only the top-level ports.
module rfsh_sched_chk #(
    parameter int RAS_CLKS = 3,
    parameter int ROW_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rfsh_ack,
    input logic                rfsh_req,
    input logic                ras_act,
    input logic                cas_block,
    input logic                hidden_go,
    input logic [ROW_BITS-1:0] rfsh_row
);
    localparam int RLW = $clog2(RAS_CLKS + 1) + 1;

    logic [RLW-1:0] ras_len;

    // Length of the current run of ras_act clocks
    always_ff @(posedge clk) begin
        if (!rst_n)       ras_len <= '0;
        else if (ras_act) ras_len <= ras_len + 1'b1;
        else              ras_len <= '0;
    end

    // R11
    no_hidden_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req |-> !hidden_go);

    // R6
    ras_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_act) |-> ($past(rfsh_ack) && $past(rfsh_req)));

    // R7
    ras_gates_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_act |-> (cas_block && rfsh_req));

    // R7
    ras_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_act |-> (ras_len < RLW'(RAS_CLKS)));

    // R7
    ras_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_act) |-> (ras_len == RLW'(RAS_CLKS)));

    // R8
    req_drop_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_req) |-> ($past(cas_block) && !$past(ras_act)));

    // R9
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hidden_go) || $fell(rfsh_req)) |->
            (rfsh_row == ROW_BITS'($past(rfsh_row) + 1'b1)));

    // R9
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hidden_go) && !$fell(rfsh_req)) |-> $stable(rfsh_row));
endmodule

bind rfsh_sched rfsh_sched_chk #(
    .RAS_CLKS (RAS_CLKS),
    .ROW_BITS (ROW_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rfsh_ack  (rfsh_ack),
    .rfsh_req  (rfsh_req),
    .ras_act   (ras_act),
    .cas_block (cas_block),
    .hidden_go (hidden_go),
    .rfsh_row  (rfsh_row)
);

// File: tb/rfsh_sched_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: small prescaler, long wait window, 3-bit rows.
module rfsh_sched_tb_top;
    localparam int P    = 16;
    localparam int WT   = 250;
    localparam int RC   = 3;
    localparam int PC   = 2;
    localparam int RB   = 3;
    localparam int OB   = 2;
    localparam int ROWS = 1 << RB;
    localparam int OMAX = (1 << OB) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_strobe = 1'b0;
    logic          ram_sel = 1'b0;
    logic [2:0]    bus_fc = 3'd0;
    logic [19:13]  bus_addr = 7'd0;
    logic          rfsh_ack = 1'b0;
    logic          rfsh_req, ras_act, cas_block, hidden_go;
    logic [RB-1:0] rfsh_row;

    int  n_cmp = 0, n_bad = 0;
    int  edge_n = 0, pres_m = 0, owed_m = 0, row_m = 0;
    bit  hid_prev = 0, req_prev = 0, rst_prev = 0, ended = 0;

    always #2 clk = ~clk;

    rfsh_sched #(
        .PRESCALE(P), .WAIT_CLKS(WT), .RAS_CLKS(RC), .PRECHG_CLKS(PC),
        .ROW_BITS(RB), .OWE_BITS(OB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ram_sel(ram_sel),
        .bus_fc(bus_fc), .bus_addr(bus_addr), .rfsh_ack(rfsh_ack),
        .rfsh_req(rfsh_req), .ras_act(ras_act), .cas_block(cas_block),
        .hidden_go(hidden_go), .rfsh_row(rfsh_row)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cop_ref(input logic [2:0] fc, input logic [6:0] a);
        return (fc == 3'd7) && (a == 7'b0010_001);
    endfunction

    function automatic bit opp_ref();
        return cyc_strobe && (!ram_sel || cop_ref(bus_fc, bus_addr));
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Arithmetic model of owed count and row, checked just before each edge.
    // Covers R2 (tick spacing), R3, R9 and R10 (saturation).
    always begin
        @(negedge clk); #1.5;
        if (!rst_prev) begin
            pres_m = 0; owed_m = 0; row_m = 0; edge_n = 0;
            hid_prev = 0; req_prev = 0;
        end else begin
            bit tk, dn;
            edge_n++;
            tk = (pres_m == P - 1);
            pres_m = (pres_m + 1) % P;
            dn = hid_prev || (req_prev && !rfsh_req);
            if (tk && !dn) owed_m = (owed_m == OMAX) ? OMAX : owed_m + 1;
            else if (!tk && dn) owed_m = owed_m - 1;
            if (dn) row_m = (row_m + 1) % ROWS;
        end
        check(hidden_go === (opp_ref() && owed_m > 0 && !rfsh_req), "R3 hidden_go",
              int'(hidden_go), int'(opp_ref() && owed_m > 0 && !rfsh_req));
        check(rfsh_row === RB'(row_m), "R9 rfsh_row", int'(rfsh_row), row_m);
        hid_prev = hidden_go;
        req_prev = rfsh_req;
        rst_prev = rst_n;
    end

    task automatic at_sample();
        @(negedge clk); #1.6;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        finish_run();
    end

    initial begin
        int hits, seen_wrap, prev_row, start;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1.6;
        check({rfsh_req, ras_act, cas_block, hidden_go} == 4'b0, "R1 outputs",
              int'({rfsh_req, ras_act, cas_block, hidden_go}), 0);
        check(rfsh_row == 0, "R1 row", int'(rfsh_row), 0);
        @(negedge clk); rst_n = 1'b1;
        #1.6;
        check(rfsh_req == 0 && rfsh_row == 0, "R1 after release", int'(rfsh_req), 0);

        // R4: full decode sweep while a refresh is owed and not yet requested
        while (edge_n < 20) at_sample();
        for (int c = 0; c < 128; c++) begin
            @(negedge clk);
            for (int j = 0; j < 16; j++) begin
                int idx;
                bit e;
                idx = c * 16 + j;
                bus_fc = 3'(idx >> 8);
                bus_addr = 7'(idx >> 1);
                ram_sel = idx[0];
                cyc_strobe = 1'b1;
                #0.04;
                e = owed_m > 0 && !rfsh_req && (!ram_sel || cop_ref(bus_fc, bus_addr));
                check(hidden_go === e, "R4 decode", int'(hidden_go), int'(e));
                #0.04;
            end
            cyc_strobe = 1'b0;
        end
        ram_sel = 1'b0; bus_fc = 3'd0; bus_addr = 7'd0;

        // R2, R5: first request lands at edge PRESCALE + WAIT_CLKS
        while (!rfsh_req && edge_n < 2000) at_sample();
        check(edge_n == P + WT, "R5 first request edge", edge_n, P + WT);

        // R6, R11: request held without ack, no RAS, no hidden refresh
        for (int k = 0; k < 60; k++) begin
            @(negedge clk); cyc_strobe = 1'b1; ram_sel = 1'b0;
            #1.6;
            check(rfsh_req && !ras_act && !hidden_go, "R6 hold",
                  int'({rfsh_req, ras_act, hidden_go}), 4);
        end
        check(!hidden_go, "R11 no hidden while requesting", int'(hidden_go), 0);

        // R7, R8: ack, RAS phase, precharge gap, request drop
        @(negedge clk); cyc_strobe = 1'b0; rfsh_ack = 1'b1;
        #1.6;
        @(negedge clk); rfsh_ack = 1'b0;
        for (int s = 1; s <= RC + PC + 1; s++) begin
            int exp_v;
            if (s != 1) @(negedge clk);
            #1.6;
            exp_v = (s <= RC) ? 7 : (s <= RC + PC) ? 3 : 0;
            if (s <= RC)
                check({ras_act, cas_block, rfsh_req} == 3'(exp_v), "R7 ras phase",
                      int'({ras_act, cas_block, rfsh_req}), exp_v);
            else
                check({ras_act, cas_block, rfsh_req} == 3'(exp_v), "R8 precharge/drop",
                      int'({ras_act, cas_block, rfsh_req}), exp_v);
        end

        // R10: saturated owed count leaves two more refreshes to take at once
        @(negedge clk); cyc_strobe = 1'b1; ram_sel = 1'b0;
        #1.6;
        check(hidden_go == 1, "R10 backlog 1", int'(hidden_go), 1);
        at_sample();
        check(hidden_go == 1, "R10 backlog 2", int'(hidden_go), 1);

        // R9: keep opportunities flowing until the row counter wraps
        seen_wrap = 0;
        prev_row = int'(rfsh_row);
        for (int k = 0; k < 160; k++) begin
            at_sample();
            if (prev_row == ROWS - 1 && rfsh_row == 0) seen_wrap = 1;
            prev_row = int'(rfsh_row);
        end
        check(seen_wrap == 1, "R9 row wrap", seen_wrap, 1);

        // R4: coprocessor cycle with RAM select high is still an opportunity
        @(negedge clk); ram_sel = 1'b1; bus_fc = 3'b111; bus_addr = 7'b0010_001;
        hits = 0;
        for (int k = 0; k < 40; k++) begin
            #1.6;
            if (hidden_go) hits++;
            @(negedge clk);
        end
        check(hits >= 2, "R4 coprocessor hidden count", hits, 2);

        // R4: plain RAM cycles never hide a refresh; request eventually rises
        bus_fc = 3'b101; bus_addr = 7'b0010_001;
        hits = 0; start = edge_n;
        while (!rfsh_req && edge_n < start + 1000) begin
            #1.6;
            if (hidden_go) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R4 RAM cycles hidden count", hits, 0);
        check(rfsh_req == 1, "R5 request after RAM-only traffic", int'(rfsh_req), 1);
        cyc_strobe = 1'b0; rfsh_ack = 1'b1;
        @(negedge clk); rfsh_ack = 1'b0;
        repeat (10) at_sample();
        check(rfsh_req == 0, "R8 request released", int'(rfsh_req), 0);

        finish_run();
    end
endmodule